// File: doc/BRIEF.md
# Interleaved Cache Line Fetch Controller

This block fills one four-word cache line from a main memory split into four banks by the low word-address bits. The word offset bits of a byte address (bits 3:2) pick the bank, and the bits above the line offset form a row address that every bank sees. On a line request the controller spends one cycle presenting the row, starts all four banks at the same time, waits out the fixed access latency, and then returns one word per cycle over a single 32-bit response bus. Only one bank drives that bus in any cycle.

The banks are small synthesizable RAMs, each followed by a read pipeline whose depth is the access latency. A word write port loads the banks. A build-time parameter selects a narrow organisation in its place. In that mode the controller reads one word at a time and steps the word index itself, so each word pays the full access latency. The two organisations can then be compared on identical contents.

Top module: `ilv_line_fetch`

## Requirements
- R1: While reset is held and after it is released, req_ready is 1, and rsp_valid, rsp_done and bus_oe are all 0.
- R2: A write stores wr_data in bank wr_addr[3:2] at row wr_addr[9:4]. wr_addr[1:0] and the bits above 9 are ignored. A later fetch of that row returns, as word k, the data last written with wr_addr[3:2] = k.
- R3: A request is taken at a rising edge only when req_valid and req_ready are both 1. req_ready is 0 from the cycle after acceptance until the cycle of the last word, when it is 1 again. A request raised while busy has no effect on the line being delivered and starts nothing afterwards.
- R4: The words of a line come out in index order 0, 1, 2, 3. Each word is marked by rsp_valid = 1, and rsp_idx carries its 2-bit index.
- R5: In interleaved mode, count cycles from the accepting edge (the cycle after it is cycle 1). Word k is then valid in cycle 1 + 15 + 1 + k, so the line ends in cycle 20.
- R6: In narrow mode, word k is valid in cycle 1 + 15·(k+1) + (k+1), so the line ends in cycle 65.
- R7: rsp_done is 1 in exactly one cycle per line: the cycle of word 3.
- R8: bus_oe is one-hot with bit rsp_idx set while rsp_valid is 1, and is 0 otherwise.
- R9: req_addr[3:0] does not affect which words are returned or in what order.
- R10: A request presented in the cycle of a line's last word is accepted at the following edge, and its line follows with the latency of R5 or R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Line fetch request |
| req_addr | input | 32 | Byte address inside the wanted line |
| req_ready | output | 1 | Controller idle, request can be taken |
| wr_en | input | 1 | Word write strobe into the bank array |
| wr_addr | input | 32 | Byte address of the word to write |
| wr_data | input | 32 | Word to write |
| rsp_valid | output | 1 | A line word is on rsp_data |
| rsp_idx | output | 2 | Index of that word within the line |
| rsp_data | output | 32 | Returned word |
| rsp_done | output | 1 | Last word of the line |
| bus_oe | output | 4 | Per-bank drive enable for the response bus |

## Verification
Lines are fetched from rows holding a distinct value in each bank. A word delivered out of order or from the wrong bank therefore shows up as a data mismatch, not just as a wrong index. The same rows are fetched through an interleaved instance and a narrow instance, so per-word arrival cycles separate the two latency models while the data must agree. Addresses with nonzero low nibbles, a request held during a busy line, a request issued in the done cycle, and a rewrite of one bank word separately show that the offset bits are ignored, that busy requests are dropped, that the done cycle hands over cleanly, and that writes land in the correct bank.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_XFER
    } fetch_st_e;

    // Cycle (counted from the accepting edge) in which word k appears.
    function automatic int word_cycle(int k, int lat, bit ilv);
        if (ilv)
            return 1 + lat + 1 + k;
        return 1 + (k + 1) * lat + (k + 1);
    endfunction

    // Cycle in which the last word of a line appears.
    function automatic int line_cycles(int words, int lat, bit ilv);
        return word_cycle(words - 1, lat, ilv);
    endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int DATA_W     = 32,
    parameter int ROW_W      = 6,
    parameter int ACCESS_LAT = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ROW_W-1:0]  rd_row,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ROW_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              vld_q [ACCESS_LAT];
    logic [DATA_W-1:0] dat_q [ACCESS_LAT];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_row] <= wr_data;
    end

    // Valid tokens march through the access pipeline.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ACCESS_LAT; i++)
                vld_q[i] <= 1'b0;
        end else begin
            vld_q[0] <= rd_en;
            for (int i = 1; i < ACCESS_LAT; i++)
                vld_q[i] <= vld_q[i-1];
        end
    end

    // Each stage loads only behind a token, so the last stage keeps
    // its word until the next read arrives.
    always_ff @(posedge clk) begin
        if (rd_en)
            dat_q[0] <= mem[rd_row];
        for (int i = 1; i < ACCESS_LAT; i++)
            if (vld_q[i-1])
                dat_q[i] <= dat_q[i-1];
    end

    assign rd_valid = vld_q[ACCESS_LAT-1];
    assign rd_data  = dat_q[ACCESS_LAT-1];

endmodule

// File: rtl/ilv_fetch_ctrl.sv
module ilv_fetch_ctrl
    import ilv_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int LINE_WORDS  = 4,
    parameter int ROW_W       = 6,
    parameter bit INTERLEAVED = 1'b1,
    localparam int IDX_W      = $clog2(LINE_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [ROW_W-1:0]      req_row,
    output logic                  req_ready,
    output logic [LINE_WORDS-1:0] rd_en,
    output logic [ROW_W-1:0]      rd_row,
    input  logic [LINE_WORDS-1:0] bank_vld,
    input  logic [DATA_W-1:0]     bank_data [LINE_WORDS],
    output logic                  rsp_valid,
    output logic [IDX_W-1:0]      rsp_idx,
    output logic [DATA_W-1:0]     rsp_data,
    output logic                  rsp_done,
    output logic [LINE_WORDS-1:0] bus_oe
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_WORDS - 1);

    fetch_st_e        state;
    logic [IDX_W-1:0] idx;
    logic [ROW_W-1:0] row_q;
    logic             take_word;
    logic             is_last;

    assign req_ready = (state == ST_IDLE);
    assign rd_row    = row_q;
    assign is_last   = (idx == LAST_IDX);
    assign take_word = (state == ST_XFER) || ((state == ST_WAIT) && bank_vld[idx]);

    always_comb begin
        rd_en = '0;
        if (state == ST_SEND) begin
            if (INTERLEAVED)
                rd_en = '1;
            else
                rd_en[idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            idx       <= '0;
            row_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_idx   <= '0;
            rsp_data  <= '0;
            rsp_done  <= 1'b0;
            bus_oe    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_done  <= 1'b0;
            bus_oe    <= '0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        row_q <= req_row;
                        idx   <= '0;
                        state <= ST_SEND;
                    end
                end
                ST_SEND: state <= ST_WAIT;
                default: ;
            endcase
            if (take_word) begin
                rsp_valid   <= 1'b1;
                rsp_idx     <= idx;
                rsp_data    <= bank_data[idx];
                rsp_done    <= is_last;
                bus_oe[idx] <= 1'b1;
                if (is_last) begin
                    state <= ST_IDLE;
                end else begin
                    idx   <= IDX_W'(idx + 1'b1);
                    state <= INTERLEAVED ? ST_XFER : ST_SEND;
                end
            end
        end
    end

endmodule

// File: rtl/ilv_line_fetch.sv
module ilv_line_fetch #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int LINE_WORDS  = 4,
    parameter int ROW_W       = 6,
    parameter int ACCESS_LAT  = 15,
    parameter bit INTERLEAVED = 1'b1,
    localparam int IDX_W      = $clog2(LINE_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    output logic                  req_ready,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic                  rsp_valid,
    output logic [IDX_W-1:0]      rsp_idx,
    output logic [DATA_W-1:0]     rsp_data,
    output logic                  rsp_done,
    output logic [LINE_WORDS-1:0] bus_oe
);
    localparam int BYTE_OFS_W = 2;
    localparam int ROW_LSB    = BYTE_OFS_W + IDX_W;

    logic [ROW_W-1:0]      req_row;
    logic [ROW_W-1:0]      wr_row;
    logic [IDX_W-1:0]      wr_bank;
    logic [LINE_WORDS-1:0] rd_en;
    logic [ROW_W-1:0]      rd_row;
    logic [LINE_WORDS-1:0] bank_vld;
    logic [DATA_W-1:0]     bank_data [LINE_WORDS];
    logic                  addr_unused;

    assign req_row     = req_addr[ROW_LSB +: ROW_W];
    assign wr_row      = wr_addr[ROW_LSB +: ROW_W];
    assign wr_bank     = wr_addr[BYTE_OFS_W +: IDX_W];
    assign addr_unused = ^{req_addr, wr_addr};

    for (genvar b = 0; b < LINE_WORDS; b++) begin : g_bank
        ilv_bank #(
            .DATA_W    (DATA_W),
            .ROW_W     (ROW_W),
            .ACCESS_LAT(ACCESS_LAT)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en && (wr_bank == IDX_W'(b))),
            .wr_row  (wr_row),
            .wr_data (wr_data),
            .rd_en   (rd_en[b]),
            .rd_row  (rd_row),
            .rd_valid(bank_vld[b]),
            .rd_data (bank_data[b])
        );
    end

    ilv_fetch_ctrl #(
        .DATA_W     (DATA_W),
        .LINE_WORDS (LINE_WORDS),
        .ROW_W      (ROW_W),
        .INTERLEAVED(INTERLEAVED)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_row  (req_row),
        .req_ready(req_ready),
        .rd_en    (rd_en),
        .rd_row   (rd_row),
        .bank_vld (bank_vld),
        .bank_data(bank_data),
        .rsp_valid(rsp_valid),
        .rsp_idx  (rsp_idx),
        .rsp_data (rsp_data),
        .rsp_done (rsp_done),
        .bus_oe   (bus_oe)
    );

endmodule

// File: rtl/ilv_line_fetch_chk.sv
module ilv_line_fetch_chk
    import ilv_pkg::*;
#(
    parameter int LINE_WORDS  = 4,
    parameter int ACCESS_LAT  = 15,
    parameter bit INTERLEAVED = 1'b1,
    localparam int IDX_W      = $clog2(LINE_WORDS)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic                  rsp_valid,
    input logic [IDX_W-1:0]      rsp_idx,
    input logic                  rsp_done,
    input logic [LINE_WORDS-1:0] bus_oe
);
    localparam int LINE_CYC = line_cycles(LINE_WORDS, ACCESS_LAT, INTERLEAVED);

    logic             busy;
    logic [15:0]      cyc;
    logic [IDX_W-1:0] exp_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cyc     <= '0;
            exp_idx <= '0;
        end else if (req_valid && req_ready) begin
            busy    <= 1'b1;
            cyc     <= 16'd1;
            exp_idx <= '0;
        end else begin
            if (busy)
                cyc <= cyc + 16'd1;
            if (rsp_valid)
                exp_idx <= IDX_W'(exp_idx + 1'b1);
            if (rsp_done)
                busy <= 1'b0;
        end
    end

    assert_bus_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_oe) && ((|bus_oe) == rsp_valid));

    assert_bus_lane_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> bus_oe[rsp_idx]);

    assert_word_order_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (busy && (rsp_idx == exp_idx)));

    assert_done_last_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (rsp_valid && (rsp_idx == IDX_W'(LINE_WORDS - 1))));

    // R6 shares this check in the narrow build.
    assert_line_latency_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (cyc == 16'(LINE_CYC)));

    assert_busy_not_ready_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !rsp_done) |-> !req_ready);

    assert_accept_drops_ready_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    if (INTERLEAVED) begin : g_burst
        assert_burst_gapless_R5: assert property (@(posedge clk) disable iff (rst)
            (rsp_valid && !rsp_done) |=> rsp_valid);
    end

endmodule

bind ilv_line_fetch ilv_line_fetch_chk #(
    .LINE_WORDS (LINE_WORDS),
    .ACCESS_LAT (ACCESS_LAT),
    .INTERLEAVED(INTERLEAVED)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .rsp_idx  (rsp_idx),
    .rsp_done (rsp_done),
    .bus_oe   (bus_oe)
);

// File: tb/ilv_line_fetch_tb.sv
module ilv_line_fetch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 15;
    localparam int WORDS      = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid_i = 1'b0, req_valid_n = 1'b0;
    logic [31:0] req_addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_addr = '0, wr_data = '0;

    logic        i_ready, i_valid, i_done, n_ready, n_valid, n_done;
    logic [1:0]  i_idx, n_idx;
    logic [31:0] i_data, n_data;
    logic [3:0]  i_oe, n_oe;

    logic [31:0] model [WORDS][64];
    int tests = 0, fails = 0, wd = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ilv_line_fetch u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid_i), .req_addr(req_addr),
        .req_ready(i_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rsp_valid(i_valid), .rsp_idx(i_idx), .rsp_data(i_data),
        .rsp_done(i_done), .bus_oe(i_oe));

    ilv_line_fetch #(.INTERLEAVED(1'b0)) u_dut_nar (
        .clk(clk), .rst(rst), .req_valid(req_valid_n), .req_addr(req_addr),
        .req_ready(n_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rsp_valid(n_valid), .rsp_idx(n_idx), .rsp_data(n_data),
        .rsp_done(n_done), .bus_oe(n_oe));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_cyc(input bit nar, input int k);
        if (nar) return 1 + (k + 1) * LAT + (k + 1);
        return 1 + LAT + 1 + k;
    endfunction

    task automatic wr_word(input int row, input int bank, input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        // Upper bits and byte offset set to show they are ignored (R2).
        wr_addr = 32'hFFFF_FC00 | (row << 4) | (bank << 2) | 32'd3;
        wr_data = d;
        model[bank][row] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic start(input bit nar, input int row, input logic [3:0] low);
        @(negedge clk);
        req_addr = (row << 4) | 32'(low);
        if (nar) req_valid_n = 1'b1; else req_valid_i = 1'b1;
        @(posedge clk);
    endtask

    // Called right after the accepting edge; follows one line to its end.
    task automatic collect(input bit nar, input int row, input bit poke,
                           input bit chain, input int chain_row, input string tag);
        int  k = 0;
        bit  seen = 1'b0;
        for (int n = 1; n <= 100 && !seen; n++) begin
            logic v, d, rdy;
            logic [1:0] ix;
            logic [31:0] dat;
            logic [3:0] oe;
            @(negedge clk);
            if (n == 1) begin req_valid_i = 1'b0; req_valid_n = 1'b0; end
            if (poke && n == 5) begin
                req_addr = ((row + 1) << 4);
                if (nar) req_valid_n = 1'b1; else req_valid_i = 1'b1;
            end
            if (poke && n == 8) begin req_valid_i = 1'b0; req_valid_n = 1'b0; end
            v   = nar ? n_valid : i_valid;
            d   = nar ? n_done  : i_done;
            rdy = nar ? n_ready : i_ready;
            ix  = nar ? n_idx   : i_idx;
            dat = nar ? n_data  : i_data;
            oe  = nar ? n_oe    : i_oe;
            if (v) begin
                chk(n == exp_cyc(nar, k), nar ? "R6" : "R5", {tag, " word cycle"}, n, exp_cyc(nar, k));
                chk(ix == 2'(k), "R4", {tag, " word index"}, ix, k);
                chk(dat == model[k][row], "R2", {tag, " word data"}, dat, model[k][row]);
                chk(oe == 4'(1 << k), "R8", {tag, " bus enable"}, oe, 1 << k);
                chk(d == (k == WORDS - 1), "R7", {tag, " done flag"}, d, k == WORDS - 1);
                k++;
                seen = d;
            end else if (oe != 4'b0 || d) begin
                chk(1'b0, "R8", {tag, " enable or done without word"}, {oe, d}, 0);
            end
            if (rdy != d) chk(1'b0, "R3", {tag, " ready while busy"}, rdy, d);
            if (seen && chain) begin
                req_addr = (chain_row << 4) | 32'h8;
                if (nar) req_valid_n = 1'b1; else req_valid_i = 1'b1;
            end
        end
        chk(seen && k == WORDS, "R4", {tag, " words delivered"}, k, WORDS);
    endtask

    task automatic quiet(input int cycles, input string tag);
        bit ok = 1'b1;
        for (int n = 0; n < cycles; n++) begin
            @(negedge clk);
            if (i_valid || n_valid || !i_ready || !n_ready) ok = 1'b0;
        end
        chk(ok, "R3", {tag, " no stray words, idle"}, ok, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(i_ready && n_ready, "R1", "ready in reset", {i_ready, n_ready}, 2'b11);
        chk(!i_valid && !n_valid && !i_done && !n_done, "R1", "valid/done in reset",
            {i_valid, n_valid, i_done, n_done}, 0);
        chk(i_oe == 0 && n_oe == 0, "R1", "bus enable in reset", {i_oe, n_oe}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(i_ready && !i_valid && i_oe == 0, "R1", "state after release",
            {i_ready, i_valid, i_oe}, 6'b100000);
    endtask

    task automatic t_fill();
        foreach (model[b, r]) model[b][r] = 32'h0;
        for (int b = 0; b < WORDS; b++) begin
            wr_word(0, b, 32'hC000_0000 | (b << 4));
            wr_word(5, b, 32'hA500_0050 | (b << 12) | b);
            wr_word(6, b, 32'h6600_0000 | b);
            wr_word(63, b, 32'h3F00_0000 | (b << 20) | 32'hF);
        end
    endtask

    task automatic t_basic_ilv();      // R5 R4 R2
        start(1'b0, 5, 4'h0);
        collect(1'b0, 5, 1'b0, 1'b0, 0, "interleaved row5");
        quiet(3, "after interleaved");
    endtask

    task automatic t_low_bits();       // R9
        start(1'b0, 63, 4'hF);
        collect(1'b0, 63, 1'b0, 1'b0, 0, "R9 offset F");
        start(1'b0, 6, 4'h9);
        collect(1'b0, 6, 1'b0, 1'b0, 0, "R9 offset 9");
        quiet(2, "after offset");
    endtask

    task automatic t_narrow();         // R6
        start(1'b1, 5, 4'h4);
        collect(1'b1, 5, 1'b0, 1'b0, 0, "narrow row5");
        quiet(3, "after narrow");
    endtask

    task automatic t_busy_ignore();    // R3
        start(1'b0, 5, 4'h0);
        collect(1'b0, 5, 1'b1, 1'b0, 0, "R3 busy request ilv");
        quiet(40, "R3 busy request dropped");
        start(1'b1, 5, 4'h0);
        collect(1'b1, 5, 1'b1, 1'b0, 0, "R3 busy request nar");
        quiet(40, "R3 busy request dropped nar");
    endtask

    task automatic t_back_to_back();   // R10
        start(1'b0, 0, 4'h0);
        collect(1'b0, 0, 1'b0, 1'b1, 63, "R10 first");
        @(posedge clk);
        collect(1'b0, 63, 1'b0, 1'b0, 0, "R10 second");
        start(1'b1, 63, 4'h0);
        collect(1'b1, 63, 1'b0, 1'b1, 0, "R10 nar first");
        @(posedge clk);
        collect(1'b1, 0, 1'b0, 1'b0, 0, "R10 nar second");
        quiet(3, "after R10");
    endtask

    task automatic t_rewrite();        // R2
        wr_word(6, 2, 32'hDEAD_BEEF);
        start(1'b0, 6, 4'h0);
        collect(1'b0, 6, 1'b0, 1'b0, 0, "R2 rewrite ilv");
        start(1'b1, 6, 4'h0);
        collect(1'b1, 6, 1'b0, 1'b0, 0, "R2 rewrite nar");
    endtask

    initial begin
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 20000) begin
                tests++;
                fails++;
                $display("FAIL watchdog: actual %0d expected below 20000 cycles", wd);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_fill();
        t_basic_ilv();
        t_low_bits();
        t_narrow();
        t_busy_ignore();
        t_back_to_back();
        t_rewrite();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule